// File: doc/BRIEF.md
# Power-Stage Fault Monitor and Status Encoder

This block watches the health of a multi-channel switching power stage and decides when every half-bridge output must be forced to high impedance. It takes digitized supply readings for the logic supply and for each gate-drive supply, a digitized junction temperature, and a held overload flag from the overcurrent circuitry. It drives a fault Hi-Z request and two active-low status lines, `sd_no` for shutdown and `otw_no` for thermal warning.

Each supply has its own low-voltage detector with hysteresis. The temperature goes through two hysteretic detectors, a warning level and a higher error level. Undervoltage and thermal error clear by themselves once the condition is gone. An overload stays held until a rising edge on the external reset line or a power-on-reset pulse. While the external reset line is low, both status lines read high whatever faults are present. The Hi-Z request is not masked.

Top module: `pstage_fault_mon`

## Requirements
- R1: Supply codes are in millivolts (1 mV per LSB). A supply whose code is below 10000 marks that supply undervolted, and a single supply is enough. It stays undervolted until its code reaches 10250 or more. A code of exactly 10000 does not trip.
- R2: Temperature codes are in degrees C (1 per LSB). A code above 125 sets the thermal warning. The warning clears only when the code is 100 or less. A code of 125 does not set it.
- R3: A temperature code above 155 sets the thermal error, which clears when the code is 130 or less. The warning is always active while the error is active. A code of 155 does not set the error.
- R4: A high `ovld_i` sets a held overload. The held overload survives `ovld_i` going low. It clears only on the edge where `reset_n_i` is sampled high after being sampled low, or on `por_i`. If `ovld_i` is high on that same edge, setting wins.
- R5: `sd_no` is low when undervoltage, overload or thermal error is active. `otw_no` is low when the warning or the error is active. {sd_no,otw_no} = 00 for a thermal error, 01 for overload or undervoltage without warning, 10 for warning only, 11 for normal.
- R6: A low `reset_n_i` forces `sd_no` and `otw_no` high on the next cycle, whatever faults are present. `hiz_req_o` is not affected.
- R7: Fault state is registered one clock after the input is sampled. `hiz_req_o` (OR of undervoltage, overload and error) follows from that state. `sd_no` and `otw_no` come from registers one clock later still, so they never glitch.
- R8: A `por_i` sampled high clears all fault state on that edge, including the held overload. It takes priority over new detections.
- R9: While `rst_ni` is low, `hiz_req_o` is 0 and `sd_no`/`otw_no` are 1.
- R10: Undervoltage and thermal error recover automatically, with no reset, once their release condition is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on-reset pulse, clears all fault state |
| reset_n_i | input | 1 | External active-low reset line; masks status and releases overload on rising edge |
| vdd_code_i | input | VW | Logic supply reading, mV |
| gvdd_code_i | input | NUM_GATE*VW | Gate-drive supply readings, supply k in bits [k*VW +: VW] |
| temp_i | input | TW | Junction temperature reading, degrees C |
| ovld_i | input | 1 | Overload flag from the overcurrent block |
| sd_no | output | 1 | Shutdown status, active low, registered |
| otw_no | output | 1 | Thermal warning status, active low, registered |
| hiz_req_o | output | 1 | Request to put all half-bridges in Hi-Z |

## Verification
Any input change reaches `hiz_req_o` one clock later and reaches `sd_no`/`otw_no` two clocks later. Reset masking reaches the status lines one clock after `reset_n_i` is sampled. The bench steps a behavioural reference model on each rising edge, using the same sampled inputs. It compares all three outputs 2 ns after that edge, so every result is checked in the cycle it becomes due, never earlier or later. The stimulus sits on each trip and release threshold and at one code on either side of it. It also changes several fault causes in a single cycle, to show that the latencies hold when causes combine.

// File: rtl/pstage_fault_pkg.sv
package pstage_fault_pkg;
  typedef struct packed {
    logic uv;
    logic ovl;
    logic err;
    logic warn;
  } fault_t;
endpackage

// File: rtl/uv_detect.sv
module uv_detect #(
  parameter int VW   = 14,
  parameter int TRIP = 10000,
  parameter int HYST = 250
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [VW-1:0] code_i,
  output logic          uv_o
);
  localparam logic [VW-1:0] TripC = VW'(TRIP);
  localparam logic [VW-1:0] RelC  = VW'(TRIP + HYST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              uv_o <= 1'b0;
    else if (clr_i)           uv_o <= 1'b0;
    else if (code_i < TripC)  uv_o <= 1'b1;
    else if (code_i >= RelC)  uv_o <= 1'b0;
  end
endmodule

// File: rtl/temp_level.sv
module temp_level #(
  parameter int TW   = 8,
  parameter int TRIP = 125,
  parameter int HYST = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] temp_i,
  output logic          hot_o
);
  localparam logic [TW-1:0] TripC = TW'(TRIP);
  localparam logic [TW-1:0] RelC  = TW'(TRIP - HYST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hot_o <= 1'b0;
    else if (clr_i)           hot_o <= 1'b0;
    else if (temp_i > TripC)  hot_o <= 1'b1;
    else if (temp_i <= RelC)  hot_o <= 1'b0;
  end
endmodule

// File: rtl/ovld_hold.sv
module ovld_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ovld_i,
  input  logic reset_n_i,
  output logic held_o
);
  logic rstn_prev_q;
  logic release_edge;

  assign release_edge = reset_n_i & ~rstn_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o      <= 1'b0;
      rstn_prev_q <= 1'b1;
    end else begin
      rstn_prev_q <= reset_n_i;
      if (clr_i)             held_o <= 1'b0;
      else if (ovld_i)       held_o <= 1'b1;
      else if (release_edge) held_o <= 1'b0;
    end
  end
endmodule

// File: rtl/status_enc.sv
module status_enc
  import pstage_fault_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  fault_t flags_i,
  input  logic   reset_n_i,
  output logic   sd_no,
  output logic   otw_no
);
  logic shut, warn;

  assign shut = flags_i.uv | flags_i.ovl | flags_i.err;
  assign warn = flags_i.warn | flags_i.err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_no  <= 1'b1;
      otw_no <= 1'b1;
    end else begin
      sd_no  <= ~shut | ~reset_n_i;
      otw_no <= ~warn | ~reset_n_i;
    end
  end
endmodule

// File: rtl/pstage_fault_mon.sv
module pstage_fault_mon
  import pstage_fault_pkg::*;
#(
  parameter int NUM_GATE  = 2,
  parameter int VW        = 14,
  parameter int TW        = 8,
  parameter int UV_TRIP   = 10000,
  parameter int UV_HYST   = 250,
  parameter int WARN_TRIP = 125,
  parameter int WARN_HYST = 25,
  parameter int ERR_TRIP  = 155,
  parameter int ERR_HYST  = 25
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   por_i,
  input  logic                   reset_n_i,
  input  logic [VW-1:0]          vdd_code_i,
  input  logic [NUM_GATE*VW-1:0] gvdd_code_i,
  input  logic [TW-1:0]          temp_i,
  input  logic                   ovld_i,
  output logic                   sd_no,
  output logic                   otw_no,
  output logic                   hiz_req_o
);
  localparam int NSUP = NUM_GATE + 1;

  logic [NSUP*VW-1:0] sup_codes;
  logic [NSUP-1:0]    uv_q;
  logic               warn_q, err_q, ovl_q;
  fault_t             flags;

  assign sup_codes = {gvdd_code_i, vdd_code_i};

  for (genvar s = 0; s < NSUP; s++) begin : g_sup
    uv_detect #(.VW(VW), .TRIP(UV_TRIP), .HYST(UV_HYST)) u_uv (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (por_i),
      .code_i(sup_codes[s*VW +: VW]),
      .uv_o  (uv_q[s])
    );
  end

  temp_level #(.TW(TW), .TRIP(WARN_TRIP), .HYST(WARN_HYST)) u_warn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (por_i),
    .temp_i(temp_i),
    .hot_o (warn_q)
  );

  temp_level #(.TW(TW), .TRIP(ERR_TRIP), .HYST(ERR_HYST)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (por_i),
    .temp_i(temp_i),
    .hot_o (err_q)
  );

  ovld_hold u_ovl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (por_i),
    .ovld_i   (ovld_i),
    .reset_n_i(reset_n_i),
    .held_o   (ovl_q)
  );

  assign flags.uv   = |uv_q;
  assign flags.ovl  = ovl_q;
  assign flags.err  = err_q;
  assign flags.warn = warn_q;

  assign hiz_req_o = flags.uv | flags.ovl | flags.err;

  status_enc u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags),
    .reset_n_i(reset_n_i),
    .sd_no    (sd_no),
    .otw_no   (otw_no)
  );
endmodule

// File: rtl/pstage_fault_mon_chk.sv
module pstage_fault_mon_chk #(
  parameter int NSUP = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            por_i,
  input logic            reset_n_i,
  input logic            ovld_i,
  input logic            sd_no,
  input logic            otw_no,
  input logic            hiz_req_o,
  input logic            warn_q,
  input logic            err_q,
  input logic            ovl_q,
  input logic [NSUP-1:0] uv_q
);
  // R3: error implies warning
  a_r3_err_implies_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> warn_q);

  // R6: masked status while reset line was low
  a_r6_reset_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reset_n_i) |-> (sd_no && otw_no));

  // R5 / R7: shutdown status follows Hi-Z request one cycle later
  a_r7_sd_follows_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reset_n_i) |-> (sd_no == !$past(hiz_req_o)));

  // R4: overload is captured
  a_r4_ovl_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovld_i && !por_i) |=> ovl_q);

  // R4: overload is held without a release event
  a_r4_ovl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_q && !por_i && !$rose(reset_n_i)) |=> ovl_q);

  // R8: power-on reset clears everything
  a_r8_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!ovl_q && !err_q && !warn_q && (uv_q == '0)));
endmodule

bind pstage_fault_mon pstage_fault_mon_chk #(.NSUP(NUM_GATE + 1)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .por_i    (por_i),
  .reset_n_i(reset_n_i),
  .ovld_i   (ovld_i),
  .sd_no    (sd_no),
  .otw_no   (otw_no),
  .hiz_req_o(hiz_req_o),
  .warn_q   (warn_q),
  .err_q    (err_q),
  .ovl_q    (ovl_q),
  .uv_q     (uv_q)
);

// File: tb/pstage_fault_mon_tb.sv
`timescale 1ns/1ps
module pstage_fault_mon_tb;
  localparam int NG = 2;
  localparam int NS = NG + 1;
  localparam int VW = 14;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni, por, reset_n, ovld;
  logic [VW-1:0] sup [NS];
  logic [TW-1:0] temp;
  logic sd_n, otw_n, hiz;

  always #4 clk = ~clk;

  pstage_fault_mon u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .por_i      (por),
    .reset_n_i  (reset_n),
    .vdd_code_i (sup[0]),
    .gvdd_code_i({sup[2], sup[1]}),
    .temp_i     (temp),
    .ovld_i     (ovld),
    .sd_no      (sd_n),
    .otw_no     (otw_n),
    .hiz_req_o  (hiz)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R9";

  // reference model
  bit m_uv [NS];
  bit m_warn, m_err, m_ovl, m_prev, m_sd, m_otw;

  function automatic bit any_uv();
    for (int i = 0; i < NS; i++) if (m_uv[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit shut;
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) m_uv[i] = 0;
      m_warn = 0; m_err = 0; m_ovl = 0; m_prev = 1; m_sd = 1; m_otw = 1;
    end else begin
      shut  = any_uv() || m_ovl || m_err;
      m_sd  = !shut || !reset_n;
      m_otw = !(m_warn || m_err) || !reset_n;
      for (int i = 0; i < NS; i++) begin
        if (sup[i] < 10000) m_uv[i] = 1;
        else if (sup[i] >= 10250) m_uv[i] = 0;
      end
      if (temp > 125) m_warn = 1; else if (temp <= 100) m_warn = 0;
      if (temp > 155) m_err = 1;  else if (temp <= 130) m_err = 0;
      if (ovld) m_ovl = 1; else if (reset_n && !m_prev) m_ovl = 0;
      m_prev = reset_n;
      if (por) begin
        for (int i = 0; i < NS; i++) m_uv[i] = 0;
        m_warn = 0; m_err = 0; m_ovl = 0;
      end
    end
    #2;
    if (!done) begin
      bit e_hiz;
      e_hiz = rst_ni && (any_uv() || m_ovl || m_err);
      total++;
      if ({hiz, sd_n, otw_n} !== {e_hiz, m_sd, m_otw}) begin
        bad++;
        $display("FAIL %s t=%0t hiz/sd/otw actual=%b%b%b expected=%b%b%b",
                 cur_req, $time, hiz, sd_n, otw_n, e_hiz, m_sd, m_otw);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL R7 watchdog actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; por = 0; reset_n = 1; ovld = 0; temp = 25;
    for (int i = 0; i < NS; i++) sup[i] = 12000;
    cur_req = "R9";
    cyc(3);
    total++;
    if ({hiz, sd_n, otw_n} !== 3'b011) begin
      bad++;
      $display("FAIL R9 reset state actual=%b%b%b expected=011", hiz, sd_n, otw_n);
    end
    rst_ni = 1;
    cur_req = "R5"; cyc(3);
    // undervoltage, per supply, with hysteresis
    cur_req = "R1";
    sup[2] = 9999;  cyc(3);
    sup[2] = 10100; cyc(3);
    sup[2] = 10249; cyc(2);
    cur_req = "R10";
    sup[2] = 10250; cyc(3);
    cur_req = "R1";
    sup[0] = 10000; cyc(2);
    sup[0] = 5000;  cyc(2);
    sup[1] = 9000;  cyc(2);
    sup[0] = 12000; cyc(2);
    cur_req = "R10";
    sup[1] = 12000; cyc(3);
    // thermal warning
    cur_req = "R2";
    temp = 125; cyc(2);
    temp = 126; cyc(3);
    temp = 101; cyc(2);
    temp = 100; cyc(3);
    // thermal error
    cur_req = "R3";
    temp = 155; cyc(2);
    temp = 156; cyc(3);
    temp = 131; cyc(2);
    cur_req = "R10";
    temp = 130; cyc(2);
    temp = 100; cyc(3);
    // combined encoding
    cur_req = "R5";
    sup[1] = 9500; cyc(3);
    temp = 140;    cyc(3);
    temp = 25;     cyc(2);
    sup[1] = 12000; cyc(3);
    // overload hold
    cur_req = "R4";
    ovld = 1; cyc(1);
    ovld = 0; cyc(5);
    // reset masking and overload release
    cur_req = "R6";
    reset_n = 0; cyc(3);
    temp = 160;  cyc(2);
    temp = 25;   cyc(3);
    cur_req = "R4";
    reset_n = 1; cyc(4);
    ovld = 1; reset_n = 0; cyc(1);
    reset_n = 1; cyc(1);
    ovld = 0; cyc(3);
    // power-on reset clears
    cur_req = "R8";
    por = 1; temp = 170; sup[2] = 8000; cyc(1);
    por = 0; cyc(3);
    temp = 25; sup[2] = 12000; cyc(2);
    por = 1; cyc(1);
    por = 0; cyc(3);
    // simultaneous changes
    cur_req = "R7";
    temp = 130; ovld = 1; sup[0] = 9000; cyc(1);
    ovld = 0; sup[0] = 12000; temp = 160; cyc(3);
    temp = 25; reset_n = 0; cyc(1);
    reset_n = 1; cyc(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule